// File: doc/BRIEF.md
# Configuration Row Mover

This block is a sequencer for compacting a row-based reconfigurable array. It moves one contiguous configuration of N rows from a source base row to a destination base row. It does this by driving the array's relocating configuration port. That port has a read offset register and a write offset register, each of which is added to a logical row address. It also has a one-row staging buffer. The sequencer loads the source base into the read offset and the destination base into the write offset. For every row it then issues one fetch of the array row into the staging buffer, followed by one commit of the buffer back to the array. Both the fetch and the commit use the same logical row address.

The source and destination regions may overlap. To keep the configuration from overwriting rows it has not yet copied, the row order follows the direction of the move. When moving toward row zero, logical row 0 is copied first and the order ascends. When moving away from row zero, the last logical row is copied first and the order descends. A command whose source or destination region would run past the last array row is rejected before any port activity. The block does not decide which configurations to compact, and it keeps no occupancy map.

Top module: `cfg_row_mover`

## Requirements
- R1: A start pulse seen while idle is accepted. In the next cycle `ld_rd_ofs_o` is high with `ofs_val_o` equal to the source base. In the cycle after that, `ld_wr_ofs_o` is high with `ofs_val_o` equal to the destination base.
- R2: Each row is moved in two consecutive cycles. The first has `fetch_o` high and the second has `commit_o` high, and `row_addr_o` holds the same logical row in both. `busy_o` is high for exactly 2·N+2 cycles.
- R3: The offset load strobes are high only in the two setup cycles, so both offsets stay fixed while rows move. At most one of the four port strobes is high in any cycle.
- R4: If destination < source, logical rows are moved in the order 0, 1, …, N-1.
- R5: If destination > source, logical rows are moved in the order N-1, N-2, …, 0.
- R6: If N = 0, or if destination = source, the two setup cycles are issued and then done follows, with no fetch or commit.
- R7: `done_o` is a one-cycle pulse in the cycle right after the last busy cycle. The block is idle in the cycle after that.
- R8: A start pulse that arrives while a move is in progress changes nothing in that move's port sequence.
- R9: If source + N > NUM_ROWS, or destination + N > NUM_ROWS, then in the cycle after start `err_o` is high for one cycle. In that case there is no busy, no strobe and no done.
- R10: After reset all outputs are low and the offset and row values are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Command strobe |
| src_base_i | input | AW | First array row of the configuration |
| dst_base_i | input | AW | First array row of its new location |
| row_cnt_i | input | CW | Number of rows N (0..NUM_ROWS) |
| busy_o | output | 1 | Move in progress |
| done_o | output | 1 | One-cycle completion pulse |
| err_o | output | 1 | One-cycle range rejection pulse |
| ld_rd_ofs_o | output | 1 | Load the read offset with `ofs_val_o` |
| ld_wr_ofs_o | output | 1 | Load the write offset with `ofs_val_o` |
| ofs_val_o | output | AW | Offset value for the load strobes |
| fetch_o | output | 1 | Read array row (row_addr + read offset) into the staging buffer |
| commit_o | output | 1 | Write the staging buffer to array row (row_addr + write offset) |
| row_addr_o | output | AW | Logical row address for a fetch or commit |

## Verification
The hardest state to reach is a start pulse that lands in the middle of a move. It must leave the latched bases and the row order alone. The bench injects a second command, with different bases and count, in the first fetch cycle. It then compares every following cycle of the port sequence against the sequence computed for the original command. The overlapping cases are reached with regions that share rows in both directions. The range limit is probed with regions that end exactly at the last row and with regions one row past it.

// File: rtl/cfg_row_mover_pkg.sv
package cfg_row_mover_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_LD_RD,
    ST_LD_WR,
    ST_FETCH,
    ST_COMMIT,
    ST_FIN,
    ST_ERR
  } mv_state_e;

endpackage

// File: rtl/mover_range_chk.sv
module mover_range_chk #(
  parameter int unsigned NUM_ROWS = 48,
  parameter int unsigned AW       = 6,
  parameter int unsigned CW       = 6
) (
  input  logic [AW-1:0] src_i,
  input  logic [AW-1:0] dst_i,
  input  logic [CW-1:0] cnt_i,
  output logic          fits_o,
  output logic          null_o,
  output logic          down_o
);

  localparam int unsigned SW = ((AW > CW) ? AW : CW) + 2;

  logic [SW-1:0] src_end;
  logic [SW-1:0] dst_end;

  assign src_end = SW'(src_i) + SW'(cnt_i);
  assign dst_end = SW'(dst_i) + SW'(cnt_i);
  assign fits_o  = (src_end <= SW'(NUM_ROWS)) && (dst_end <= SW'(NUM_ROWS));
  assign null_o  = (cnt_i == '0) || (src_i == dst_i);
  // moving away from row zero: copy the bottom row first
  assign down_o  = dst_i > src_i;

endmodule

// File: rtl/mover_row_seq.sv
module mover_row_seq #(
  parameter int unsigned AW = 6,
  parameter int unsigned CW = 6
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          load_i,
  input  logic          step_i,
  input  logic          down_i,
  input  logic [CW-1:0] cnt_i,
  output logic [AW-1:0] row_o,
  output logic          last_o
);

  logic [AW-1:0] row_q;
  logic [CW-1:0] left_q;
  logic          down_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      row_q  <= '0;
      left_q <= '0;
      down_q <= 1'b0;
    end else if (load_i) begin
      row_q  <= down_i ? AW'(cnt_i - CW'(1)) : '0;
      left_q <= cnt_i;
      down_q <= down_i;
    end else if (step_i) begin
      row_q  <= down_q ? row_q - AW'(1) : row_q + AW'(1);
      left_q <= left_q - CW'(1);
    end
  end

  assign row_o  = row_q;
  assign last_o = (left_q == CW'(1));

endmodule

// File: rtl/mover_port_drv.sv
module mover_port_drv
  import cfg_row_mover_pkg::*;
#(
  parameter int unsigned AW = 6
) (
  input  mv_state_e     state_i,
  input  logic [AW-1:0] src_i,
  input  logic [AW-1:0] dst_i,
  input  logic [AW-1:0] row_i,
  output logic          busy_o,
  output logic          done_o,
  output logic          err_o,
  output logic          ld_rd_ofs_o,
  output logic          ld_wr_ofs_o,
  output logic [AW-1:0] ofs_val_o,
  output logic          fetch_o,
  output logic          commit_o,
  output logic [AW-1:0] row_addr_o
);

  always_comb begin
    busy_o      = 1'b0;
    done_o      = 1'b0;
    err_o       = 1'b0;
    ld_rd_ofs_o = 1'b0;
    ld_wr_ofs_o = 1'b0;
    ofs_val_o   = '0;
    fetch_o     = 1'b0;
    commit_o    = 1'b0;
    row_addr_o  = '0;
    unique case (state_i)
      ST_LD_RD: begin
        busy_o      = 1'b1;
        ld_rd_ofs_o = 1'b1;
        ofs_val_o   = src_i;
      end
      ST_LD_WR: begin
        busy_o      = 1'b1;
        ld_wr_ofs_o = 1'b1;
        ofs_val_o   = dst_i;
      end
      ST_FETCH: begin
        busy_o     = 1'b1;
        fetch_o    = 1'b1;
        row_addr_o = row_i;
      end
      ST_COMMIT: begin
        busy_o     = 1'b1;
        commit_o   = 1'b1;
        row_addr_o = row_i;
      end
      ST_FIN:  done_o = 1'b1;
      ST_ERR:  err_o  = 1'b1;
      default: ;
    endcase
  end

endmodule

// File: rtl/cfg_row_mover.sv
module cfg_row_mover
  import cfg_row_mover_pkg::*;
#(
  parameter int unsigned NUM_ROWS = 48,
  localparam int unsigned AW = (NUM_ROWS > 1) ? $clog2(NUM_ROWS) : 1,
  localparam int unsigned CW = $clog2(NUM_ROWS + 1)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          start_i,
  input  logic [AW-1:0] src_base_i,
  input  logic [AW-1:0] dst_base_i,
  input  logic [CW-1:0] row_cnt_i,
  output logic          busy_o,
  output logic          done_o,
  output logic          err_o,
  output logic          ld_rd_ofs_o,
  output logic          ld_wr_ofs_o,
  output logic [AW-1:0] ofs_val_o,
  output logic          fetch_o,
  output logic          commit_o,
  output logic [AW-1:0] row_addr_o
);

  mv_state_e     state_q, state_d;
  logic [AW-1:0] src_q, dst_q;
  logic [CW-1:0] cnt_q;
  logic          null_q, down_q;
  logic          fits, null_mv, down;
  logic          accept;
  logic          seq_load, seq_step, seq_last;
  logic [AW-1:0] seq_row;

  mover_range_chk #(
    .NUM_ROWS(NUM_ROWS),
    .AW      (AW),
    .CW      (CW)
  ) i_range (
    .src_i (src_base_i),
    .dst_i (dst_base_i),
    .cnt_i (row_cnt_i),
    .fits_o(fits),
    .null_o(null_mv),
    .down_o(down)
  );

  // commands are taken only from idle; all other states ignore start
  assign accept   = (state_q == ST_IDLE) && start_i;
  assign seq_load = (state_q == ST_LD_WR) && !null_q;
  assign seq_step = (state_q == ST_COMMIT) && !seq_last;

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ST_IDLE:   if (start_i) state_d = fits ? ST_LD_RD : ST_ERR;
      ST_LD_RD:  state_d = ST_LD_WR;
      ST_LD_WR:  state_d = null_q ? ST_FIN : ST_FETCH;
      ST_FETCH:  state_d = ST_COMMIT;
      ST_COMMIT: state_d = seq_last ? ST_FIN : ST_FETCH;
      ST_FIN:    state_d = ST_IDLE;
      ST_ERR:    state_d = ST_IDLE;
      default:   state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      src_q   <= '0;
      dst_q   <= '0;
      cnt_q   <= '0;
      null_q  <= 1'b0;
      down_q  <= 1'b0;
    end else begin
      state_q <= state_d;
      if (accept) begin
        src_q  <= src_base_i;
        dst_q  <= dst_base_i;
        cnt_q  <= row_cnt_i;
        null_q <= null_mv;
        down_q <= down;
      end
    end
  end

  mover_row_seq #(
    .AW(AW),
    .CW(CW)
  ) i_seq (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .load_i(seq_load),
    .step_i(seq_step),
    .down_i(down_q),
    .cnt_i (cnt_q),
    .row_o (seq_row),
    .last_o(seq_last)
  );

  mover_port_drv #(
    .AW(AW)
  ) i_drv (
    .state_i    (state_q),
    .src_i      (src_q),
    .dst_i      (dst_q),
    .row_i      (seq_row),
    .busy_o     (busy_o),
    .done_o     (done_o),
    .err_o      (err_o),
    .ld_rd_ofs_o(ld_rd_ofs_o),
    .ld_wr_ofs_o(ld_wr_ofs_o),
    .ofs_val_o  (ofs_val_o),
    .fetch_o    (fetch_o),
    .commit_o   (commit_o),
    .row_addr_o (row_addr_o)
  );

endmodule

// File: rtl/cfg_row_mover_chk.sv
module cfg_row_mover_chk #(
  parameter int unsigned AW = 6
) (
  input logic          clk_i,
  input logic          rst_ni,
  input logic          busy_o,
  input logic          done_o,
  input logic          err_o,
  input logic          ld_rd_ofs_o,
  input logic          ld_wr_ofs_o,
  input logic          fetch_o,
  input logic          commit_o,
  input logic [AW-1:0] row_addr_o
);

  // R1
  wr_after_rd_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ld_rd_ofs_o |=> ld_wr_ofs_o);

  // R2
  commit_same_row_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fetch_o |=> (commit_o && row_addr_o == $past(row_addr_o)));

  // R2
  commit_needs_fetch_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    commit_o |-> $past(fetch_o));

  // R3
  one_strobe_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0({ld_rd_ofs_o, ld_wr_ofs_o, fetch_o, commit_o}));

  // R3
  strobe_busy_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ld_rd_ofs_o || ld_wr_ofs_o || fetch_o || commit_o) |-> busy_o);

  // R7
  done_pulse_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o && !busy_o);

  // R7
  done_after_busy_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(done_o) |-> $past(busy_o));

  // R9
  err_quiet_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    err_o |-> (!busy_o && !done_o));

endmodule

bind cfg_row_mover cfg_row_mover_chk #(
  .AW(AW)
) i_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .busy_o     (busy_o),
  .done_o     (done_o),
  .err_o      (err_o),
  .ld_rd_ofs_o(ld_rd_ofs_o),
  .ld_wr_ofs_o(ld_wr_ofs_o),
  .fetch_o    (fetch_o),
  .commit_o   (commit_o),
  .row_addr_o (row_addr_o)
);

// File: tb/test_cfg_row_mover.sv
module test_cfg_row_mover;

  localparam int CLK_PERIOD = 10;
  localparam int NUM_ROWS   = 48;
  localparam int AW         = $clog2(NUM_ROWS);
  localparam int CW         = $clog2(NUM_ROWS + 1);
  localparam int VW         = 7 + 2 * AW;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          start = 1'b0;
  logic [AW-1:0] src = '0;
  logic [AW-1:0] dst = '0;
  logic [CW-1:0] cnt = '0;
  logic          busy, done, err, ld_rd, ld_wr, fetch, commit;
  logic [AW-1:0] ofs, row;

  int total = 0;
  int bad   = 0;
  int cyc   = 0;

  cfg_row_mover #(.NUM_ROWS(NUM_ROWS)) i_cfg_row_mover (
    .clk_i      (clk),
    .rst_ni     (rst_n),
    .start_i    (start),
    .src_base_i (src),
    .dst_base_i (dst),
    .row_cnt_i  (cnt),
    .busy_o     (busy),
    .done_o     (done),
    .err_o      (err),
    .ld_rd_ofs_o(ld_rd),
    .ld_wr_ofs_o(ld_wr),
    .ofs_val_o  (ofs),
    .fetch_o    (fetch),
    .commit_o   (commit),
    .row_addr_o (row)
  );

  always #(CLK_PERIOD / 2) clk = ~clk;

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc > 20000) begin
      bad = bad + 1;
      $display("FAIL watchdog: run hung (all requirements)");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  function automatic logic [VW-1:0] pk(input logic b, d, e, lr, lw, f, c,
                                       input logic [AW-1:0] o, r);
    return {b, d, e, lr, lw, f, c, o, r};
  endfunction

  task automatic chk(input string tag, input logic [VW-1:0] exp_v);
    logic [VW-1:0] got;
    got = pk(busy, done, err, ld_rd, ld_wr, fetch, commit, ofs, row);
    total++;
    if (got !== exp_v) begin
      bad++;
      $display("FAIL %s t=%0t got=%h exp=%h", tag, $time, got, exp_v);
    end
  endtask

  // R10
  task automatic t_reset();
    @(negedge clk);
    chk("R10 reset", pk(0, 0, 0, 0, 0, 0, 0, '0, '0));
    rst_n = 1'b1;
    @(negedge clk);
    chk("R10 idle", pk(0, 0, 0, 0, 0, 0, 0, '0, '0));
  endtask

  // R1 R2 R3 R4 R5 R6 R7 R8: full cycle-by-cycle sequence of one move
  task automatic t_move(input int s, input int d, input int n, input bit inject, input string tag);
    int m;
    m = (n == 0 || s == d) ? 0 : n;
    @(negedge clk);
    src = AW'(s); dst = AW'(d); cnt = CW'(n); start = 1'b1;
    for (int k = 1; k <= 2 * m + 4; k++) begin
      @(negedge clk);
      start = 1'b0;
      if (k == 1) chk({tag, " R1 ld_rd"}, pk(1, 0, 0, 1, 0, 0, 0, AW'(s), '0));
      else if (k == 2) chk({tag, " R1 ld_wr"}, pk(1, 0, 0, 0, 1, 0, 0, AW'(d), '0));
      else if (k <= 2 * m + 2) begin
        int j, r;
        j = (k - 3) / 2;
        r = (d > s) ? (m - 1 - j) : j;
        if ((k - 3) % 2 == 0) chk({tag, " R2 fetch"}, pk(1, 0, 0, 0, 0, 1, 0, '0, AW'(r)));
        else chk({tag, " R2 commit"}, pk(1, 0, 0, 0, 0, 0, 1, '0, AW'(r)));
      end
      else if (k == 2 * m + 3) chk({tag, " R7 done"}, pk(0, 1, 0, 0, 0, 0, 0, '0, '0));
      else chk({tag, " R7 idle"}, pk(0, 0, 0, 0, 0, 0, 0, '0, '0));
      if (inject && k == 3) begin
        // R8: foreign command mid-move
        src = AW'(1); dst = AW'(40); cnt = CW'(2); start = 1'b1;
      end
    end
  endtask

  // R9
  task automatic t_err(input int s, input int d, input int n, input string tag);
    @(negedge clk);
    src = AW'(s); dst = AW'(d); cnt = CW'(n); start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    chk({tag, " R9 err"}, pk(0, 0, 1, 0, 0, 0, 0, '0, '0));
    @(negedge clk);
    chk({tag, " R9 quiet"}, pk(0, 0, 0, 0, 0, 0, 0, '0, '0));
    @(negedge clk);
    chk({tag, " R9 quiet2"}, pk(0, 0, 0, 0, 0, 0, 0, '0, '0));
  endtask

  initial begin
    t_reset();
    t_move(10, 4, 8, 0, "R4 up overlap");
    t_move(4, 9, 6, 0, "R5 down overlap");
    t_move(30, 0, 3, 0, "R4 up disjoint");
    t_move(0, 44, 4, 0, "R5 exact fit");
    t_move(47, 0, 1, 0, "R4 last row");
    t_move(5, 7, 0, 0, "R6 zero rows");
    t_move(12, 12, 5, 0, "R6 same base");
    t_err(46, 0, 3, "src past end");
    t_err(0, 45, 4, "dst past end");
    t_err(50, 0, 0, "src base beyond");
    t_move(20, 16, 3, 1, "R8 start while busy");
    t_move(16, 20, 3, 1, "R8 R5 start while busy");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule